// File: doc/BRIEF.md
# Log-depth leading/trailing zero counter

This block takes an N-bit data vector and reports, in the same cycle, how many zero bits sit in front of the first set bit. A direction parameter picks where the scan starts: at the most significant end (leading zeros) or at the least significant end (trailing zeros). A variant parameter picks the output format. The full format is one bit wider so that an all-zero input reads back as N. The short format is narrower, and its value for an all-zero input is not defined.

Internally the vector is split in half again and again down to single bits. Each subtree returns a count whose top bit is set exactly when that subtree holds no ones. Each pair of halves is merged with one multiplexer level, so the logic depth grows with log2(N) instead of N. For trailing zeros the input is reversed, so the same tree serves both directions.

When N is not a power of two, the vector is padded with zeros at the top up to the next power of two. The pad length is then subtracted from the tree result, and the difference is cut to the output width. The block has no clock and no state.

Top module: `zcount_tree`

## Requirements
- R1: With the full variant, an all-zero input gives a count of exactly N. The output width is ceil(log2(N+1)) bits, which is 4 bits for N=12 and 3 bits for N=5.
- R2: In leading mode (DIR=ZC_LEAD), a nonzero input gives N-1 minus the bit index of its highest set bit. Bit 0 is the least significant bit.
- R3: In trailing mode (DIR=ZC_TRAIL), a nonzero input gives the bit index of its lowest set bit. With the full variant, an all-zero input gives N.
- R4: With the short variant (VAR=ZC_SHORT), the output is ceil(log2(N)) bits wide, which is 4 bits for N=16. For every nonzero input it equals the full-variant count.
- R5: For a width that is not a power of two (N=12, N=5), the count follows R1 to R3 exactly. This holds for inputs whose only set bits lie just below the top position.
- R6: A vector with only its most significant bit set counts 0 in leading mode. A vector with only bit 0 set counts N-1 in leading mode.
- R7: The output is a pure function of the present input. A new input shows at count_o without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Vector to be scanned |
| count_o | output | ceil(log2(N+1)) full, ceil(log2(N)) short | Number of zeros ahead of the first set bit |

## Verification
The hardest case to reach is the lower-half merge path in every tree level at once. It is taken only when each upper half is empty, and it must also produce the zero flag. Inputs whose single set bit or run of ones sits low in the vector force this path at successive depths. The walk covers every one-hot position, every run of low ones, and every vector with k low zeros followed by ones. For non-power-of-two widths, the padded top must never be counted. The pad subtraction is driven both from the all-zero input and from inputs whose top set bit sits right under the pad.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic { ZC_LEAD = 1'b0, ZC_TRAIL = 1'b1 } zc_dir_e;
  typedef enum logic { ZC_FULL = 1'b0, ZC_SHORT = 1'b1 } zc_var_e;

  // Smallest r with 2**r >= v.
  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/zc_merge.sv
// Combines two half counts of width HW; each carries its all-zero flag in its MSB.
module zc_merge #(
  parameter int HW = 1
) (
  input  logic [HW-1:0] hi_cnt_i,
  input  logic [HW-1:0] lo_cnt_i,
  output logic [HW:0]   cnt_o
);
  localparam int HALF = 1 << (HW - 1);

  function automatic logic [HW:0] join_halves(input logic [HW-1:0] hi, input logic [HW-1:0] lo);
    logic [HW:0] r;
    r = '0;
    if (!hi[HW-1]) begin
      r[HW-1:0] = hi;
    end else begin
      for (int i = 0; i < HW - 1; i++) r[i] = lo[i];
      r[HW-1] = ~lo[HW-1];
      r[HW]   = lo[HW-1];
    end
    return r;
  endfunction

  logic hi_empty, lo_empty;
  assign hi_empty = hi_cnt_i[HW-1];
  assign lo_empty = lo_cnt_i[HW-1];
  assign cnt_o    = join_halves(hi_cnt_i, lo_cnt_i);

  always_comb begin
    if (!$isunknown({hi_cnt_i, lo_cnt_i})) begin
      // R1: merged zero flag set only when both halves are empty
      a_r1_flag_merge: assert (cnt_o[HW] == (hi_empty && lo_empty));
      // R2: an occupied upper half keeps the count inside that half
      a_r2_hi_first: assert (hi_empty || (int'(cnt_o) < HALF));
      // R2: an empty upper half pushes the count to at least HALF
      a_r2_lo_offset: assert (!hi_empty || (int'(cnt_o) >= HALF));
    end
  end
endmodule

// File: rtl/zc_node.sv
// Recursive leading-zero tree for a power-of-two width W; result MSB is the zero flag.
module zc_node #(
  parameter int W = 16
) (
  input  logic [W-1:0]                   vec_i,
  output logic [zc_pkg::ceil_log2(W):0]  cnt_o
);
  localparam int LW = zc_pkg::ceil_log2(W);

  generate
    if (W == 1) begin : g_leaf
      // R2: a single bit counts one zero exactly when it is clear
      assign cnt_o = ~vec_i;
    end else begin : g_split
      localparam int HW2 = W / 2;
      logic [LW-1:0] hi_cnt, lo_cnt;
      zc_node #(.W(HW2)) i_hi (.vec_i(vec_i[W-1:HW2]), .cnt_o(hi_cnt));
      zc_node #(.W(HW2)) i_lo (.vec_i(vec_i[HW2-1:0]), .cnt_o(lo_cnt));
      zc_merge #(.HW(LW)) i_merge (.hi_cnt_i(hi_cnt), .lo_cnt_i(lo_cnt), .cnt_o(cnt_o));
    end
  endgenerate
endmodule

// File: rtl/zcount_tree.sv
module zcount_tree #(
  parameter int              N   = 12,
  parameter zc_pkg::zc_dir_e DIR = zc_pkg::ZC_LEAD,
  parameter zc_pkg::zc_var_e VAR = zc_pkg::ZC_FULL,
  localparam int FW = zc_pkg::ceil_log2(N + 1),
  localparam int SW = zc_pkg::ceil_log2(N),
  localparam int OW = (VAR == zc_pkg::ZC_FULL) ? FW : SW
) (
  input  logic [N-1:0]  data_i,
  output logic [OW-1:0] count_o
);
  localparam int LP  = zc_pkg::ceil_log2(N);
  localparam int NP  = 1 << LP;
  localparam int PAD = NP - N;

  logic [N-1:0]  oriented;
  logic [NP-1:0] padded;
  logic [LP:0]   tree_cnt;
  logic [LP:0]   adjusted;
  logic [FW-1:0] full_cnt;

  initial begin
    if (N < 4) $error("zcount_tree: N must be at least 4");
  end

  generate
    if (DIR == zc_pkg::ZC_LEAD) begin : g_lead
      assign oriented = data_i;
    end else begin : g_trail
      for (genvar i = 0; i < N; i++) begin : g_rev
        assign oriented[i] = data_i[N-1-i];
      end
    end
    if (PAD == 0) begin : g_nopad
      assign padded = oriented;
    end else begin : g_pad
      assign padded = {{PAD{1'b0}}, oriented};
    end
  endgenerate

  zc_node #(.W(NP)) i_root (.vec_i(padded), .cnt_o(tree_cnt));

  assign adjusted = tree_cnt - (LP + 1)'(PAD);
  assign full_cnt = adjusted[FW-1:0];
  assign count_o  = full_cnt[OW-1:0];

  always_comb begin
    if (!$isunknown(data_i)) begin
      // R5: the padded top is always counted, so subtraction never wraps
      a_r5_no_underflow: assert (int'(tree_cnt) >= PAD);
      // R1: empty input counts N
      a_r1_zero_is_n: assert ((data_i != '0) || (int'(full_cnt) == N));
      // R2: any set bit keeps the count below N
      a_r2_in_range: assert ((data_i == '0) || (int'(full_cnt) < N));
      // R3: the counted position holds the first one, nothing ahead of it
      a_r3_first_one: assert ((data_i == '0) || (int'(full_cnt) >= N) ||
                              ((oriented >> (N - 1 - int'(full_cnt))) == 1));
    end
  end
endmodule

// File: tb/test_zcount_tree.sv
module test_zcount_tree;
  import zc_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [11:0] in_a;  logic [3:0] out_a;
  logic [15:0] in_b;  logic [3:0] out_b;
  logic [4:0]  in_c;  logic [2:0] out_c;

  zcount_tree i_zcount_tree (.data_i(in_a), .count_o(out_a));
  zcount_tree #(.N(16), .DIR(ZC_TRAIL), .VAR(ZC_SHORT)) i_zcount_tree_b (.data_i(in_b), .count_o(out_b));
  zcount_tree #(.N(5),  .DIR(ZC_TRAIL), .VAR(ZC_FULL))  i_zcount_tree_c (.data_i(in_c), .count_o(out_c));

  // {12-bit data, expected leading count} for N=12, leading, full
  localparam logic [15:0] VEC [12] = '{
    16'h000C, 16'h8000, 16'h001B, 16'h4001, 16'h0FF4, 16'hFFF0,
    16'h0107, 16'h5551, 16'hAAA0, 16'h0A04, 16'h002A, 16'h1003 };

  function automatic int ref_lead(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) if (v[i]) return n - 1 - i;
    return n;
  endfunction

  function automatic int ref_trail(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) if (v[i]) return i;
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    @(negedge clk);
    in_a = v[11:0]; in_b = v; in_c = v[4:0];
    #1;
    chk((v[11:0] == 0) ? "R1 N=12 zero" : "R2/R5 N=12 lead", int'(out_a), ref_lead({4'h0, v[11:0]}, 12));
    if (v != 0) chk("R3/R4 N=16 trail short", int'(out_b), ref_trail(v, 16));
    chk("R3/R5 N=5 trail full", int'(out_c), ref_trail({11'h0, v[4:0]}, 5));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    in_a = '0; in_b = '0; in_c = '0;
    #2;
    // initial state: all-zero inputs
    chk("R1 initial zero N=12", int'(out_a), 12);
    chk("R3 initial zero N=5", int'(out_c), 5);
    chk("R1 width N=12 full", $bits(out_a), 4);
    chk("R1 width N=5 full", $bits(out_c), 3);
    chk("R4 width N=16 short", $bits(out_b), 4);

    foreach (VEC[i]) begin
      @(negedge clk);
      in_a = VEC[i][15:4];
      #1;
      chk("R2 table", int'(out_a), int'(VEC[i][3:0]));
    end

    // R6 boundary one-hots, leading mode
    @(negedge clk); in_a = 12'h800; #1; chk("R6 msb only", int'(out_a), 0);
    @(negedge clk); in_a = 12'h001; #1; chk("R6 lsb only", int'(out_a), 11);

    // R7: change between edges, output follows with no clock edge
    @(posedge clk); #1;
    in_a = 12'h040; #1;
    chk("R7 no clock needed", int'(out_a), 5);
    in_a = 12'h000; #1;
    chk("R7 back to zero", int'(out_a), 12);

    // R5 just under the pad
    apply(16'h0800);
    apply(16'h0C00);
    apply(16'h0010);

    apply(16'h0000);
    for (int k = 0; k < 16; k++) apply(16'h1 << k);
    for (int k = 1; k <= 16; k++) apply(16'((17'h1 << k) - 1));
    for (int k = 0; k < 16; k++) apply(16'hFFFF << k);
    apply(16'hAAAA);
    apply(16'h5555);
    apply(16'h8001);
    for (int k = 0; k < 200; k++) begin
      logic [15:0] r;
      r = 16'($urandom());
      if (k % 3 == 0) r = r & (16'hFFFF >> (k % 16));
      apply(r);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule